// File: doc/BRIEF.md
# Cache Way Shrink/Expand Controller

This block governs how many ways of a 16-way shared cache may take new lines. An activity figure arrives once per sample window. When that figure stays below a low threshold for a programmable number of windows in a row, the controller shrinks the cache to two ways. It takes ways 2 through 15 out of the allocation mask one at a time, asks the cache to flush each one, and marks a way as sleeping only after the cache acknowledges its flush.

A sample above a separate high threshold restores full associativity. This holds whether the cache is fully shrunk or still part-way through flushing. The sleep bits drop first. The allocation bits return a programmable number of cycles later, which gives the arrays time to wake. Ways 0 and 1 are never touched.

All outputs are registered. The cache arrays, the writeback datapath and any supply change are handled elsewhere.

Top module: `way_shrink_ctrl`

## Requirements
- R1: After reset, alloc_mask is 16'hFFFF, sleep_mask is 16'h0000 and flush_req is 16'h0000.
- R2: A sample is low when activity < low_thresh. A shrink starts only after persist_windows consecutive low samples. Any sample that is not low resets the run count. The first allocation bit clears on the second clock edge after the final low sample.
- R3: A sample is high only when activity > high_thresh. Activity equal to low_thresh is not low, and activity equal to high_thresh is not high.
- R4: Bits 0 and 1 of alloc_mask are always 1, and bits 0 and 1 of sleep_mask are always 0.
- R5: During a shrink, a way's alloc_mask bit clears one clock edge before its flush_req bit rises. Ways are flushed in ascending order from 2 to 15, and at most one flush_req bit is high at any time.
- R6: On the clock edge that samples flush_ack[i] high while flush_req[i] is high, sleep_mask[i] sets and flush_req[i] falls.
- R7: A flush_ack bit for a way whose flush_req is low changes no output.
- R8: A completed shrink leaves alloc_mask at 16'h0003 and sleep_mask at 16'hFFFC. Further low samples change nothing.
- R9: A high sample during a flush aborts the shrink. On the second edge after that sample, flush_req and sleep_mask are both 0.
- R10: On expand, sleep_mask clears on the second edge after the high sample. alloc_mask returns to 16'hFFFF exactly wake_cycles edges later (a value of 0 acts as 1). No way is ever enabled for allocation while it is asleep.
- R11: In the full configuration, samples that are not low leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe at the end of a sample window |
| activity | input | 16 | Activity count for the window that just ended |
| low_thresh | input | 16 | Activity below this value counts as low |
| high_thresh | input | 16 | Activity above this value counts as high |
| persist_windows | input | 8 | Consecutive low samples needed before a shrink |
| wake_cycles | input | 8 | Cycles from clearing sleep to restoring allocation |
| flush_ack | input | 16 | Per-way flush completion from the cache |
| flush_req | output | 16 | Per-way flush request, at most one bit high |
| alloc_mask | output | 16 | Ways the allocation logic may fill |
| sleep_mask | output | 16 | Ways held in the sleep state |

## Verification
The bench goes after four kinds of error:
- **Persistence counting.** A low run is broken by an in-between sample and by a sample exactly equal to a threshold. A design that counted non-consecutive lows, or treated the boundary as low, would shrink one vector early.
- **Handshake ordering.** The bench checks that the allocation bit drops a cycle before its flush request. It also feeds an acknowledge on the wrong way. A design that slept a way on a stray acknowledge would show a sleep bit with no flush behind it.
- **Abort mid-flush.** A high sample arrives while a flush is still outstanding. A controller that finished the flush anyway would leave a request or sleep bit standing.
- **Wake delay.** The wake delay is timed edge by edge. Restoring allocation early would hand lines to arrays that are still asleep.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [2:0] {
    ST_FULL,
    ST_ARM,
    ST_FLUSH,
    ST_SHRUNK,
    ST_WAKE
  } seq_state_t;
endpackage

// File: rtl/wsc_activity_mon.sv
// Classifies each activity sample and tracks the run of consecutive lows.
module wsc_activity_mon #(
  parameter int ACT_W     = 16,
  parameter int PERSIST_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_valid,
  input  logic [ACT_W-1:0]     activity,
  input  logic [ACT_W-1:0]     low_thresh,
  input  logic [ACT_W-1:0]     high_thresh,
  input  logic [PERSIST_W-1:0] persist_windows,
  output logic                 low_ok,
  output logic                 high_hit
);
  localparam logic [PERSIST_W-1:0] CNT_MAX = '1;

  logic [PERSIST_W-1:0] low_cnt;
  logic [PERSIST_W-1:0] cnt_next;
  logic [PERSIST_W-1:0] need;
  logic                 is_low;
  logic                 is_high;

  always_comb begin
    is_low   = activity < low_thresh;
    is_high  = activity > high_thresh;
    cnt_next = (low_cnt == CNT_MAX) ? low_cnt : low_cnt + 1'b1;
    need     = (persist_windows == '0) ? PERSIST_W'(1) : persist_windows;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      low_ok   <= 1'b0;
      high_hit <= 1'b0;
    end else begin
      high_hit <= sample_valid && is_high;
      if (sample_valid) begin
        if (is_low) begin
          low_cnt <= cnt_next;
          low_ok  <= cnt_next >= need;
        end else begin
          low_cnt <= '0;
          low_ok  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wsc_seq.sv
// Drives allocation, flush and sleep masks through shrink, abort and wake.
module wsc_seq
  import wsc_pkg::*;
#(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2,
  parameter int WAKE_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                low_ok,
  input  logic                high_hit,
  input  logic [WAKE_W-1:0]   wake_cycles,
  input  logic [NUM_WAYS-1:0] flush_ack,
  output logic [NUM_WAYS-1:0] flush_req,
  output logic [NUM_WAYS-1:0] alloc_mask,
  output logic [NUM_WAYS-1:0] sleep_mask
);
  localparam int                 IDX_W = $clog2(NUM_WAYS);
  localparam logic [IDX_W-1:0]   FIRST = IDX_W'(KEEP_WAYS);
  localparam logic [IDX_W-1:0]   LAST  = IDX_W'(NUM_WAYS - 1);
  localparam logic [NUM_WAYS-1:0] ALL  = '1;

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_inc;
  logic [WAKE_W-1:0] wcnt;
  logic [WAKE_W:0]   wnext;
  logic              abort;

  always_comb begin
    idx_inc = idx + 1'b1;
    wnext   = {1'b0, wcnt} + 1'b1;
    abort   = high_hit && (state == ST_ARM || state == ST_FLUSH || state == ST_SHRUNK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FULL;
      idx        <= FIRST;
      wcnt       <= '0;
      flush_req  <= '0;
      alloc_mask <= ALL;
      sleep_mask <= '0;
    end else if (abort) begin
      state      <= ST_WAKE;
      wcnt       <= '0;
      flush_req  <= '0;
      sleep_mask <= '0;
    end else begin
      case (state)
        ST_FULL: begin
          if (low_ok && !high_hit) begin
            idx               <= FIRST;
            alloc_mask[FIRST] <= 1'b0;
            state             <= ST_ARM;
          end
        end
        ST_ARM: begin
          flush_req[idx] <= 1'b1;
          state          <= ST_FLUSH;
        end
        ST_FLUSH: begin
          if (flush_ack[idx]) begin
            flush_req[idx]  <= 1'b0;
            sleep_mask[idx] <= 1'b1;
            if (idx == LAST) begin
              state <= ST_SHRUNK;
            end else begin
              idx                 <= idx_inc;
              alloc_mask[idx_inc] <= 1'b0;
              state               <= ST_ARM;
            end
          end
        end
        ST_SHRUNK: begin
          state <= ST_SHRUNK;
        end
        ST_WAKE: begin
          if (wnext >= {1'b0, wake_cycles}) begin
            alloc_mask <= ALL;
            state      <= ST_FULL;
          end else begin
            wcnt <= wnext[WAKE_W-1:0];
          end
        end
        default: state <= ST_FULL;
      endcase
    end
  end
endmodule

// File: rtl/way_shrink_ctrl.sv
module way_shrink_ctrl #(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2,
  parameter int ACT_W     = 16,
  parameter int PERSIST_W = 8,
  parameter int WAKE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_valid,
  input  logic [ACT_W-1:0]     activity,
  input  logic [ACT_W-1:0]     low_thresh,
  input  logic [ACT_W-1:0]     high_thresh,
  input  logic [PERSIST_W-1:0] persist_windows,
  input  logic [WAKE_W-1:0]    wake_cycles,
  input  logic [NUM_WAYS-1:0]  flush_ack,
  output logic [NUM_WAYS-1:0]  flush_req,
  output logic [NUM_WAYS-1:0]  alloc_mask,
  output logic [NUM_WAYS-1:0]  sleep_mask
);
  logic low_ok;
  logic high_hit;

  wsc_activity_mon #(.ACT_W(ACT_W), .PERSIST_W(PERSIST_W)) u_mon (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .activity(activity),
    .low_thresh(low_thresh), .high_thresh(high_thresh),
    .persist_windows(persist_windows), .low_ok(low_ok), .high_hit(high_hit)
  );

  wsc_seq #(.NUM_WAYS(NUM_WAYS), .KEEP_WAYS(KEEP_WAYS), .WAKE_W(WAKE_W)) u_seq (
    .clk(clk), .rst(rst), .low_ok(low_ok), .high_hit(high_hit),
    .wake_cycles(wake_cycles), .flush_ack(flush_ack), .flush_req(flush_req),
    .alloc_mask(alloc_mask), .sleep_mask(sleep_mask)
  );
endmodule

// File: rtl/way_shrink_chk.sv
module way_shrink_chk #(
  parameter int NUM_WAYS  = 16,
  parameter int KEEP_WAYS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_WAYS-1:0] flush_ack,
  input logic [NUM_WAYS-1:0] flush_req,
  input logic [NUM_WAYS-1:0] alloc_mask,
  input logic [NUM_WAYS-1:0] sleep_mask
);
  a_r4_keep_ways: assert property (@(posedge clk) disable iff (rst)
    (&alloc_mask[KEEP_WAYS-1:0]) && (sleep_mask[KEEP_WAYS-1:0] == '0));

  a_r5_one_flush: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flush_req));

  a_r10_no_alloc_asleep: assert property (@(posedge clk) disable iff (rst)
    (alloc_mask & sleep_mask) == '0);

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
    a_r5_drop_first: assert property (@(posedge clk) disable iff (rst)
      $rose(flush_req[i]) |-> $past(!alloc_mask[i]) && !alloc_mask[i]);
    a_r6_sleep_after_ack: assert property (@(posedge clk) disable iff (rst)
      $rose(sleep_mask[i]) |-> $past(flush_req[i] && flush_ack[i]));
    a_r10_wake_before_alloc: assert property (@(posedge clk) disable iff (rst)
      $rose(alloc_mask[i]) |-> $past(!sleep_mask[i]));
  end
endmodule

bind way_shrink_ctrl way_shrink_chk #(.NUM_WAYS(NUM_WAYS), .KEEP_WAYS(KEEP_WAYS)) u_chk (
  .clk(clk), .rst(rst), .flush_ack(flush_ack), .flush_req(flush_req),
  .alloc_mask(alloc_mask), .sleep_mask(sleep_mask)
);

// File: tb/sim_way_shrink_ctrl.sv
`timescale 1ns/1ps
module sim_way_shrink_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_valid = 1'b0;
  logic [15:0] activity = '0;
  logic [15:0] low_thresh = 16'd10;
  logic [15:0] high_thresh = 16'd100;
  logic [7:0]  persist_windows = 8'd3;
  logic [7:0]  wake_cycles = 8'd4;
  logic [15:0] flush_ack;
  logic [15:0] flush_req, alloc_mask, sleep_mask;
  logic [15:0] ack_q = '0;
  logic [15:0] man_ack = '0;
  logic        auto_ack = 1'b1;
  int          errors = 0;
  int          checks = 0;
  int          exp_way = 2;
  int          ord_err = 0;
  int          ord_seen = 0;
  logic [15:0] last_req = '0;

  always #2 clk = ~clk;

  assign flush_ack = auto_ack ? ack_q : man_ack;

  way_shrink_ctrl u0 (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .activity(activity),
    .low_thresh(low_thresh), .high_thresh(high_thresh),
    .persist_windows(persist_windows), .wake_cycles(wake_cycles),
    .flush_ack(flush_ack), .flush_req(flush_req),
    .alloc_mask(alloc_mask), .sleep_mask(sleep_mask)
  );

  // Responder acknowledges whatever is requested, visible at the next edge.
  always @(negedge clk) begin
    ack_q <= flush_req;
    if (rst) begin
      exp_way  = 2;
      last_req = '0;
    end else begin
      if (flush_req != '0 && flush_req != last_req) begin
        if (flush_req != (16'h1 << exp_way)) ord_err++;
        exp_way++;
        ord_seen++;
      end
      last_req = flush_req;
    end
  end

  // {activity, expected alloc_mask, expected sleep_mask}
  localparam logic [47:0] VEC [15] = '{
    {16'd50,  16'hFFFF, 16'h0000},  // R11 mid sample
    {16'd5,   16'hFFFF, 16'h0000},  // R2 first low
    {16'd5,   16'hFFFF, 16'h0000},  // R2 second low
    {16'd50,  16'hFFFF, 16'h0000},  // R2 run broken
    {16'd5,   16'hFFFF, 16'h0000},
    {16'd5,   16'hFFFF, 16'h0000},
    {16'd10,  16'hFFFF, 16'h0000},  // R3 equal to low is not low
    {16'd5,   16'hFFFF, 16'h0000},
    {16'd5,   16'hFFFF, 16'h0000},
    {16'd5,   16'h0003, 16'hFFFC},  // R8 shrink completes
    {16'd5,   16'h0003, 16'hFFFC},  // R8 more lows
    {16'd100, 16'h0003, 16'hFFFC},  // R3 equal to high is not high
    {16'd200, 16'hFFFF, 16'h0000},  // R10 expand
    {16'd150, 16'hFFFF, 16'h0000},  // R11 high in full
    {16'd50,  16'hFFFF, 16'h0000}   // R11
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a);
    @(negedge clk);
    sample_valid = 1'b1;
    activity     = a;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 alloc", alloc_mask, 16'hFFFF);
    chk("R1 sleep", sleep_mask, 16'h0000);
    chk("R1 req",   flush_req,  16'h0000);

    for (int i = 0; i < 15; i++) begin
      send(VEC[i][47:32]);
      repeat (60) @(negedge clk);
      chk($sformatf("R2/R3/R8/R10/R11 vec%0d alloc", i), alloc_mask, VEC[i][31:16]);
      chk($sformatf("R2/R3/R8/R10/R11 vec%0d sleep", i), sleep_mask, VEC[i][15:0]);
      if (i == 9) begin
        chk("R5 flush order errors", 16'(ord_err), 16'd0);
        chk("R5 ways flushed", 16'(ord_seen), 16'd14);
        chk("R4 keep ways", alloc_mask & 16'h0003, 16'h0003);
      end
    end

    // Directed: manual handshake, stray ack, abort and wake timing.
    auto_ack = 1'b0;
    send(16'd5);
    send(16'd5);
    send(16'd5);
    @(negedge clk);
    chk("R2 first drop alloc", alloc_mask, 16'hFFFB);
    chk("R5 no req before drop", flush_req, 16'h0000);
    @(negedge clk);
    chk("R5 req after drop", flush_req, 16'h0004);
    man_ack = 16'h0008;
    repeat (3) @(negedge clk);
    chk("R7 stray ack req", flush_req, 16'h0004);
    chk("R7 stray ack sleep", sleep_mask, 16'h0000);
    chk("R7 stray ack alloc", alloc_mask, 16'hFFFB);
    man_ack = 16'h0004;
    @(negedge clk);
    man_ack = 16'h0000;
    chk("R6 sleep set", sleep_mask, 16'h0004);
    chk("R6 req dropped", flush_req, 16'h0000);
    chk("R5 next drop", alloc_mask, 16'hFFF3);
    @(negedge clk);
    chk("R5 next way req", flush_req, 16'h0008);
    send(16'd200);
    @(negedge clk);
    chk("R9 abort req", flush_req, 16'h0000);
    chk("R9 abort sleep", sleep_mask, 16'h0000);
    chk("R10 alloc held", alloc_mask, 16'hFFF3);
    repeat (3) @(negedge clk);
    chk("R10 alloc before wake end", alloc_mask, 16'hFFF3);
    @(negedge clk);
    chk("R10 alloc restored", alloc_mask, 16'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule